// File: doc/BRIEF.md
# DMA Channel Cycle-Type Controller

This block decides, for a single DMA channel, when a cycle runs and what happens once it has run. The channel has two control structures, a primary and an alternate. Each holds a 3-bit cycle-type code and a transfer count. Software loads either structure through a write port. A peripheral or a software request then starts the cycle held in the structure that software selected. The block works out the length of each run of transfers and hands it to the transfer scheduler with a one-cycle start pulse. It advances on the scheduler's run-complete acknowledge. When the last run is acknowledged, it retires the structure.

Three cycle types are supported. A basic cycle needs a new request before each run. An auto-request cycle is meant for memory-to-memory moves: one request from software carries it through every run. A ping-pong cycle alternates between the two structures, so software can refill the idle structure while the other one is transferring. Moving transfers on the bus and arbitrating between channels are both outside this block. The scheduler only sees start pulses and sends back acknowledges.

Top module: `dma_cycle_ctrl`

## Requirements
- R1: After synchronous reset, `run_start`, `done` and `act_alt` are 0, and both structures hold cycle type 000 (invalid) with count 0.
- R2: Cycle-type codes are 000 invalid, 001 basic, 010 auto-request and 011 ping-pong. Codes 100 to 111 behave as invalid. A cycle starts when all of these hold in the same cycle: the block is idle, `enable` is 1, `periph_req` or `sw_req` is 1, and the structure picked by `start_alt` (0 primary, 1 alternate) holds a valid code. One cycle later `run_start` pulses and `act_alt` equals `start_alt`. In every other case no run starts.
- R3: A count field of N means N+1 transfers. Each run length on `run_len` is the smaller of 2^RUN_POW and the transfers still remaining. Remaining transfers drop by the run length at each acknowledge.
- R4: When the final run is acknowledged, `done` pulses for one cycle, starting the cycle after the acknowledge. That structure's type becomes invalid, so a later request does not start it again.
- R5: In a basic cycle, after a run that is not the last, the next run starts only after a request sampled once the acknowledge has been taken.
- R6: In an auto-request cycle, after a run that is not the last, the next `run_start` pulses in the cycle after the acknowledge, with no request needed.
- R7: When a ping-pong structure completes and the other structure holds a valid code, `act_alt` toggles and the next run waits for a request. When the other structure is invalid, the cycle ends.
- R8: If software has set the other structure to basic, ping-pong switches to it, runs it as a basic cycle, and then ends.
- R9: If `enable` is 0 at a run boundary, the cycle is abandoned without a `done` pulse. The cycle type and the remaining count are kept, so re-enabling and requesting resumes the cycle.
- R10: Software may rewrite the idle structure while the other one is active. A software write takes priority over the block's own update to the same structure in the same cycle.
- R11: `run_start` never pulses while a run is still awaiting its acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Channel enable |
| periph_req | input | 1 | Peripheral request |
| sw_req | input | 1 | Software request |
| start_alt | input | 1 | Structure used at cycle start: 0 primary, 1 alternate |
| sw_we | input | 1 | Software structure write strobe |
| sw_sel | input | 1 | Written structure: 0 primary, 1 alternate |
| sw_ctype | input | 3 | Cycle-type code to write |
| sw_cnt | input | CNT_W | Count to write (transfers minus one) |
| run_ack | input | 1 | Scheduler has finished the outstanding run |
| act_alt | output | 1 | Active structure: 0 primary, 1 alternate |
| run_start | output | 1 | One-cycle pulse that issues a run |
| run_len | output | RUN_POW+1 | Transfers in the issued run, valid with `run_start` |
| done | output | 1 | One-cycle pulse when a structure's cycle completes |

## Verification
The assertions assume that the scheduler acknowledges only a run it was given, once per `run_start`, and never in the same cycle as that pulse. The bench's acknowledge responder waits for each start pulse and answers it a fixed number of cycles later, so it stays within that rule. The done-invalidates assertion also assumes that no software write lands on the same edge as the final acknowledge. The scenarios keep software writes away from acknowledge edges, except where they deliberately refill the idle structure.

// File: rtl/dma_cyc_pkg.sv
package dma_cyc_pkg;

  localparam logic [2:0] CT_INVALID  = 3'd0;
  localparam logic [2:0] CT_BASIC    = 3'd1;
  localparam logic [2:0] CT_AUTO     = 3'd2;
  localparam logic [2:0] CT_PINGPONG = 3'd3;

  localparam int NUM_DESC = 2;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_RUN  = 2'd2
  } cyc_state_e;

  function automatic logic ct_valid(input logic [2:0] code);
    return (code == CT_BASIC) || (code == CT_AUTO) || (code == CT_PINGPONG);
  endfunction

endpackage

// File: rtl/dma_desc_bank.sv
module dma_desc_bank #(
  parameter int CNT_W = 8
) (
  input  logic                                         clk,
  input  logic                                         rst,
  input  logic                                         sw_we,
  input  logic                                         sw_sel,
  input  logic [2:0]                                   sw_ctype,
  input  logic [CNT_W-1:0]                             sw_cnt,
  input  logic                                         hw_we,
  input  logic                                         hw_sel,
  input  logic [2:0]                                   hw_ctype,
  input  logic [CNT_W-1:0]                             hw_cnt,
  output logic [dma_cyc_pkg::NUM_DESC-1:0][2:0]        ctype_q,
  output logic [dma_cyc_pkg::NUM_DESC-1:0][CNT_W-1:0]  cnt_q
);
  import dma_cyc_pkg::*;

  for (genvar i = 0; i < NUM_DESC; i++) begin : g_ent
    localparam logic IDX = 1'(i);
    logic [2:0]       ty_r;
    logic [CNT_W-1:0] n_r;

    // software write wins over the controller's own update
    always_ff @(posedge clk) begin
      if (rst) begin
        ty_r <= CT_INVALID;
        n_r  <= '0;
      end else if (sw_we && (sw_sel == IDX)) begin
        ty_r <= sw_ctype;
        n_r  <= sw_cnt;
      end else if (hw_we && (hw_sel == IDX)) begin
        ty_r <= hw_ctype;
        n_r  <= hw_cnt;
      end
    end

    assign ctype_q[i] = ty_r;
    assign cnt_q[i]   = n_r;
  end

endmodule

// File: rtl/dma_run_sizer.sv
module dma_run_sizer #(
  parameter int CNT_W   = 8,
  parameter int RUN_POW = 2
) (
  input  logic [CNT_W-1:0]   cnt_i,
  output logic               last_o,
  output logic [RUN_POW:0]   len_o,
  output logic [CNT_W-1:0]   cnt_next_o,
  output logic [RUN_POW:0]   next_len_o
);
  localparam int RL_W = RUN_POW + 1;
  localparam logic [CNT_W:0]   RUN_MAX_W = (CNT_W+1)'(1) << RUN_POW;
  localparam logic [CNT_W-1:0] RUN_MAX_C = CNT_W'(1) << RUN_POW;
  localparam logic [RL_W-1:0]  RUN_MAX_L = RL_W'(1) << RUN_POW;

  logic [CNT_W:0] rem;
  logic [CNT_W:0] rem_after;

  always_comb begin
    rem        = {1'b0, cnt_i} + (CNT_W+1)'(1);
    last_o     = (rem <= RUN_MAX_W);
    len_o      = last_o ? rem[RL_W-1:0] : RUN_MAX_L;
    cnt_next_o = cnt_i - RUN_MAX_C;
    rem_after  = rem - RUN_MAX_W;
    next_len_o = (rem_after <= RUN_MAX_W) ? rem_after[RL_W-1:0] : RUN_MAX_L;
  end

endmodule

// File: rtl/dma_cycle_fsm.sv
module dma_cycle_fsm #(
  parameter int CNT_W   = 8,
  parameter int RUN_POW = 2
) (
  input  logic                                   clk,
  input  logic                                   rst,
  input  logic                                   enable,
  input  logic                                   periph_req,
  input  logic                                   sw_req,
  input  logic                                   start_alt,
  input  logic                                   run_ack,
  input  logic [dma_cyc_pkg::NUM_DESC-1:0][2:0]  ctype_q,
  input  logic                                   last_i,
  input  logic [RUN_POW:0]                       len_i,
  input  logic [CNT_W-1:0]                       cnt_next_i,
  input  logic [RUN_POW:0]                       next_len_i,
  output logic                                   rd_sel,
  output logic                                   hw_we,
  output logic                                   hw_sel,
  output logic [2:0]                             hw_ctype,
  output logic [CNT_W-1:0]                       hw_cnt,
  output logic                                   act_alt,
  output logic                                   run_start,
  output logic [RUN_POW:0]                       run_len,
  output logic                                   done
);
  import dma_cyc_pkg::*;

  cyc_state_e     st_q, st_d;
  logic           act_q, act_d;
  logic           rs_d, done_d;
  logic [RUN_POW:0] len_q, len_d;
  logic           req;
  logic [2:0]     ct_act, ct_oth, ct_start;

  assign req      = periph_req | sw_req;
  assign ct_act   = ctype_q[act_q];
  assign ct_oth   = ctype_q[~act_q];
  assign ct_start = ctype_q[start_alt];
  assign rd_sel   = (st_q == ST_IDLE) ? start_alt : act_q;

  always_comb begin
    st_d     = st_q;
    act_d    = act_q;
    rs_d     = 1'b0;
    done_d   = 1'b0;
    len_d    = len_q;
    hw_we    = 1'b0;
    hw_sel   = act_q;
    hw_ctype = ct_act;
    hw_cnt   = cnt_next_i;
    case (st_q)
      ST_IDLE: begin
        if (enable && req && ct_valid(ct_start)) begin
          act_d = start_alt;
          rs_d  = 1'b1;
          len_d = len_i;
          st_d  = ST_RUN;
        end
      end
      ST_WAIT: begin
        if (!enable || !ct_valid(ct_act)) begin
          st_d = ST_IDLE;
        end else if (req) begin
          rs_d  = 1'b1;
          len_d = len_i;
          st_d  = ST_RUN;
        end
      end
      ST_RUN: begin
        if (run_ack) begin
          hw_we = 1'b1;
          if (last_i) begin
            hw_ctype = CT_INVALID;
            hw_cnt   = '0;
            done_d   = 1'b1;
            if ((ct_act == CT_PINGPONG) && enable && ct_valid(ct_oth)) begin
              act_d = ~act_q;
              st_d  = ST_WAIT;
            end else begin
              st_d = ST_IDLE;
            end
          end else if (!enable) begin
            st_d = ST_IDLE;
          end else if (ct_act == CT_AUTO) begin
            rs_d  = 1'b1;
            len_d = next_len_i;
          end else begin
            st_d = ST_WAIT;
          end
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q      <= ST_IDLE;
      act_q     <= 1'b0;
      len_q     <= '0;
      run_start <= 1'b0;
      done      <= 1'b0;
    end else begin
      st_q      <= st_d;
      act_q     <= act_d;
      len_q     <= len_d;
      run_start <= rs_d;
      done      <= done_d;
    end
  end

  assign act_alt = act_q;
  assign run_len = len_q;

  // R11: a run awaiting acknowledge never gets another start
  p_no_overlap_r11: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_RUN && !run_ack) |=> !run_start);

  // R2: a disabled idle channel never starts
  p_idle_disabled_r2: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_IDLE && !enable) |=> !run_start);

  // R6: auto-request chains the next run without a request
  p_auto_chain_r6: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_RUN && run_ack && !last_i && enable && ct_act == CT_AUTO) |=> run_start);

  // R9: abort at a boundary gives no done pulse
  p_abort_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_RUN && run_ack && !last_i && !enable) |=> (!done && st_q == ST_IDLE));

  // R4: done is a single-cycle pulse
  p_done_pulse_r4: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

endmodule

// File: rtl/dma_cycle_ctrl.sv
module dma_cycle_ctrl #(
  parameter int CNT_W   = 8,
  parameter int RUN_POW = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               enable,
  input  logic               periph_req,
  input  logic               sw_req,
  input  logic               start_alt,
  input  logic               sw_we,
  input  logic               sw_sel,
  input  logic [2:0]         sw_ctype,
  input  logic [CNT_W-1:0]   sw_cnt,
  input  logic               run_ack,
  output logic               act_alt,
  output logic               run_start,
  output logic [RUN_POW:0]   run_len,
  output logic               done
);
  import dma_cyc_pkg::*;

  logic [NUM_DESC-1:0][2:0]       ctype_q;
  logic [NUM_DESC-1:0][CNT_W-1:0] cnt_q;
  logic                           rd_sel;
  logic                           hw_we, hw_sel;
  logic [2:0]                     hw_ctype;
  logic [CNT_W-1:0]               hw_cnt;
  logic                           last;
  logic [RUN_POW:0]               len_cur, len_nxt;
  logic [CNT_W-1:0]               cnt_next;

  dma_desc_bank #(.CNT_W(CNT_W)) u_bank (
    .clk      (clk),
    .rst      (rst),
    .sw_we    (sw_we),
    .sw_sel   (sw_sel),
    .sw_ctype (sw_ctype),
    .sw_cnt   (sw_cnt),
    .hw_we    (hw_we),
    .hw_sel   (hw_sel),
    .hw_ctype (hw_ctype),
    .hw_cnt   (hw_cnt),
    .ctype_q  (ctype_q),
    .cnt_q    (cnt_q)
  );

  dma_run_sizer #(.CNT_W(CNT_W), .RUN_POW(RUN_POW)) u_sizer (
    .cnt_i      (cnt_q[rd_sel]),
    .last_o     (last),
    .len_o      (len_cur),
    .cnt_next_o (cnt_next),
    .next_len_o (len_nxt)
  );

  dma_cycle_fsm #(.CNT_W(CNT_W), .RUN_POW(RUN_POW)) u_fsm (
    .clk        (clk),
    .rst        (rst),
    .enable     (enable),
    .periph_req (periph_req),
    .sw_req     (sw_req),
    .start_alt  (start_alt),
    .run_ack    (run_ack),
    .ctype_q    (ctype_q),
    .last_i     (last),
    .len_i      (len_cur),
    .cnt_next_i (cnt_next),
    .next_len_i (len_nxt),
    .rd_sel     (rd_sel),
    .hw_we      (hw_we),
    .hw_sel     (hw_sel),
    .hw_ctype   (hw_ctype),
    .hw_cnt     (hw_cnt),
    .act_alt    (act_alt),
    .run_start  (run_start),
    .run_len    (run_len),
    .done       (done)
  );

  // R4: a completed structure reads back invalid unless software rewrote it
  p_done_invalidates_r4: assert property (@(posedge clk) disable iff (rst)
    (done && !$past(sw_we)) |-> (ctype_q[$past(act_alt)] == CT_INVALID));

  // R3: an issued run is never empty and never longer than the run limit
  p_run_len_bound_r3: assert property (@(posedge clk) disable iff (rst)
    run_start |-> (run_len != '0 && run_len <= ((RUN_POW+1)'(1) << RUN_POW)));

endmodule

// File: tb/dma_cycle_ctrl_bench.sv
module dma_cycle_ctrl_bench;
  localparam int CNT_W   = 8;
  localparam int RUN_POW = 2;
  localparam int RMAX    = 1 << RUN_POW;
  localparam int ACK_LAT = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic enable = 1'b0, periph_req = 1'b0, sw_req = 1'b0, start_alt = 1'b0;
  logic sw_we = 1'b0, sw_sel = 1'b0;
  logic [2:0] sw_ctype = '0;
  logic [CNT_W-1:0] sw_cnt = '0;
  logic run_ack = 1'b0;
  logic act_alt, run_start, done;
  logic [RUN_POW:0] run_len;

  always #2 clk = ~clk;

  dma_cycle_ctrl #(.CNT_W(CNT_W), .RUN_POW(RUN_POW)) u_dma_cycle_ctrl (
    .clk(clk), .rst(rst), .enable(enable), .periph_req(periph_req),
    .sw_req(sw_req), .start_alt(start_alt), .sw_we(sw_we), .sw_sel(sw_sel),
    .sw_ctype(sw_ctype), .sw_cnt(sw_cnt), .run_ack(run_ack),
    .act_alt(act_alt), .run_start(run_start), .run_len(run_len), .done(done)
  );

  int n_chk = 0, n_fail = 0;
  int n_rs = 0, n_done = 0, sum_len = 0, overlap = 0, last_len = 0;
  int ack_cnt = 0, cycles = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference model
  int mst = 0, mact = 0, m_rs = 0, m_done = 0, m_len = 0;
  int mty[2], mcnt[2];

  function automatic bit vld(input int c);
    return (c == 1) || (c == 2) || (c == 3);
  endfunction
  function automatic int lenof(input int r);
    return (r < RMAX) ? r : RMAX;
  endfunction

  always @(posedge clk) begin
    int mode, rem;
    if (rst) begin
      mst = 0; mact = 0; m_rs = 0; m_done = 0; m_len = 0;
      mty[0] = 0; mty[1] = 0; mcnt[0] = 0; mcnt[1] = 0;
    end else begin
      m_rs = 0; m_done = 0;
      case (mst)
        0: if (enable && (periph_req || sw_req) && vld(mty[start_alt])) begin
             mact = int'(start_alt); m_len = lenof(mcnt[mact] + 1); m_rs = 1; mst = 2;
           end
        1: if (!enable || !vld(mty[mact])) mst = 0;
           else if (periph_req || sw_req) begin
             m_len = lenof(mcnt[mact] + 1); m_rs = 1; mst = 2;
           end
        default: if (run_ack) begin
             mode = mty[mact]; rem = mcnt[mact] + 1;
             if (rem <= RMAX) begin
               mty[mact] = 0; mcnt[mact] = 0; m_done = 1;
               if (mode == 3 && enable && vld(mty[1 - mact])) begin mact = 1 - mact; mst = 1; end
               else mst = 0;
             end else begin
               mcnt[mact] -= RMAX;
               if (!enable) mst = 0;
               else if (mode == 2) begin m_len = lenof(mcnt[mact] + 1); m_rs = 1; end
               else mst = 1;
             end
           end
      endcase
      if (sw_we) begin mty[sw_sel] = int'(sw_ctype); mcnt[sw_sel] = int'(sw_cnt); end
    end
  end

  // per-clock comparison, acknowledge responder and event counters
  always @(negedge clk) begin
    if (!rst && !finished) begin
      chk(run_start == m_rs[0], "R2 run_start vs model", int'(run_start), m_rs);
      chk(done == m_done[0], "R4 done vs model", int'(done), m_done);
      chk(act_alt == mact[0], "R7 act_alt vs model", int'(act_alt), mact);
      if (run_start) chk(int'(run_len) == m_len, "R3 run_len vs model", int'(run_len), m_len);
      if (run_start) begin n_rs++; sum_len += int'(run_len); last_len = int'(run_len); end
      if (done) n_done++;
    end
    run_ack = 1'b0;
    if (run_start) begin
      if (ack_cnt > 0) overlap++;
      ack_cnt = ACK_LAT;
    end else if (ack_cnt > 0) begin
      ack_cnt--;
      if (ack_cnt == 0) run_ack = 1'b1;
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask
  task automatic wr_desc(input bit sel, input int ty, input int cnt);
    @(negedge clk);
    sw_we = 1'b1; sw_sel = sel; sw_ctype = 3'(ty); sw_cnt = CNT_W'(cnt);
    @(negedge clk);
    sw_we = 1'b0;
  endtask
  task automatic preq();
    @(negedge clk); periph_req = 1'b1;
    @(negedge clk); periph_req = 1'b0;
    idle(6);
  endtask
  task automatic sreq();
    @(negedge clk); sw_req = 1'b1;
    @(negedge clk); sw_req = 1'b0;
  endtask

  task automatic summary();
    finished = 1;
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !finished) begin
      chk(1'b0, "watchdog", cycles, 100000);
      summary();
    end
  end

  initial begin
    int rs0, dn0, sl0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(run_start == 1'b0 && done == 1'b0 && act_alt == 1'b0, "R1 reset outputs",
        int'({run_start, done, act_alt}), 0);
    rst = 1'b0;
    enable = 1'b1;
    // R1/R2: structures reset invalid, so a request starts nothing
    rs0 = n_rs;
    preq();
    chk(n_rs == rs0, "R1 reset structures invalid", n_rs - rs0, 0);
    // R2: reserved code behaves as invalid
    wr_desc(0, 5, 0);
    preq();
    chk(n_rs == rs0, "R2 code 101 ignored", n_rs - rs0, 0);
    // R2: disabled channel ignores request
    wr_desc(0, 1, 0);
    enable = 1'b0;
    preq();
    chk(n_rs == rs0, "R2 disabled ignored", n_rs - rs0, 0);
    enable = 1'b1;
    preq();
    chk(n_rs == rs0 + 1 && n_done == 1, "R2 single-run basic", n_rs - rs0, 1);

    // R3/R5: basic, 10 transfers, primary
    wr_desc(0, 1, 9);
    start_alt = 1'b0;
    rs0 = n_rs; dn0 = n_done; sl0 = sum_len;
    preq();
    chk(n_rs == rs0 + 1, "R5 one run per request", n_rs - rs0, 1);
    idle(8);
    chk(n_rs == rs0 + 1, "R5 no run without request", n_rs - rs0, 1);
    preq();
    preq();
    chk(sum_len - sl0 == 10, "R3 total transfers", sum_len - sl0, 10);
    chk(last_len == 2, "R3 tail run length", last_len, 2);
    chk(n_done == dn0 + 1, "R4 done once", n_done - dn0, 1);
    // R4: retired structure does not restart
    rs0 = n_rs;
    preq();
    chk(n_rs == rs0, "R4 invalid after completion", n_rs - rs0, 0);

    // R6: auto-request on alternate, 11 transfers from one software request
    wr_desc(1, 2, 10);
    start_alt = 1'b1;
    rs0 = n_rs; dn0 = n_done; sl0 = sum_len;
    sreq();
    idle(40);
    chk(n_rs == rs0 + 3, "R6 auto runs", n_rs - rs0, 3);
    chk(sum_len - sl0 == 11, "R6 auto transfers", sum_len - sl0, 11);
    chk(n_done == dn0 + 1, "R6 auto done", n_done - dn0, 1);
    chk(act_alt == 1'b1, "R2 act_alt follows start_alt", int'(act_alt), 1);

    // R7/R10: ping-pong with refill of the idle structure
    wr_desc(0, 3, 3);
    wr_desc(1, 3, 5);
    start_alt = 1'b0;
    rs0 = n_rs; dn0 = n_done; sl0 = sum_len;
    preq();
    chk(act_alt == 1'b1, "R7 switched to alternate", int'(act_alt), 1);
    wr_desc(0, 3, 1);
    preq();
    preq();
    chk(act_alt == 1'b0, "R10 refilled primary taken", int'(act_alt), 0);
    preq();
    preq();
    chk(n_rs == rs0 + 4, "R7 ping-pong runs", n_rs - rs0, 4);
    chk(n_done == dn0 + 3, "R7 ping-pong done count", n_done - dn0, 3);
    chk(sum_len - sl0 == 12, "R7 ping-pong transfers", sum_len - sl0, 12);

    // R8: ping-pong handing over to a basic structure then ending
    wr_desc(0, 3, 0);
    wr_desc(1, 1, 0);
    start_alt = 1'b0;
    rs0 = n_rs; dn0 = n_done;
    preq();
    preq();
    preq();
    chk(n_rs == rs0 + 2, "R8 basic tail then stop", n_rs - rs0, 2);
    chk(n_done == dn0 + 2, "R8 done count", n_done - dn0, 2);

    // R9: disable during a run aborts at the boundary
    wr_desc(0, 1, 20);
    start_alt = 1'b0;
    rs0 = n_rs; dn0 = n_done;
    @(negedge clk); periph_req = 1'b1;
    @(negedge clk); periph_req = 1'b0;
    enable = 1'b0;
    idle(8);
    chk(n_done == dn0, "R9 no done on abort", n_done - dn0, 0);
    enable = 1'b1;
    preq();
    chk(n_rs == rs0 + 2, "R9 resumes after re-enable", n_rs - rs0, 2);
    chk(last_len == 4, "R9 remaining count kept", last_len, 4);
    enable = 1'b0;
    idle(4);

    chk(overlap == 0, "R11 no start while outstanding", overlap, 0);
    summary();
  end

endmodule